// File: doc/BRIEF.md
# Keyed XOR Payload Descrambler

This block removes a byte-wise XOR obfuscation from the data section of flash program and flash verify frames as the bytes stream past. The key is derived from the 8-byte unique identifier of the device. The UID can be loaded one byte at a time or as a single 64-bit word with a load strobe. The block adds the eight UID bytes together, keeps the low 8 bits as the base key, and from then on reports that a key is available.

The payload is treated as a run of 8-byte groups. Every byte except the last one in a group is XORed with the base key. The last byte of each group is XORed with the base key plus a fixed offset of 0x31, modulo 256. The scrambling is applied whatever session key the host has set, including all zeros.

The upstream frame parser pulses a start marker just before the first payload byte, so address and padding bytes are never counted. Descrambled bytes leave one clock after they enter, with the same valid pattern. A typical frame carries 56 payload bytes, which is seven full groups.

Top module: `payload_unscrambler`

## Requirements
- R1: While reset is held and in the first cycle after it, `dout_vld_o`, `key_ok_o` and `dout_o` are all zero.
- R2: The base key is the sum of the eight UID bytes modulo 256. In the parallel word, UID byte k sits at bits [8k+7:8k].
- R3: A serial load consists of eight bytes on `uid_byte_i` qualified by `uid_byte_vld_i`, with gaps allowed between them. The key changes only at the edge that takes the eighth byte. A load that has fewer than eight bytes leaves the key unchanged.
- R4: When `uid_vec_ld_i` and `uid_byte_vld_i` are high in the same cycle, the parallel word sets the key. The serial byte and any partly collected serial bytes are discarded.
- R5: A payload byte at group position 0 to 6 comes out XORed with the base key.
- R6: A payload byte at group position 7 comes out XORed with (base key + 0x31) mod 256.
- R7: A byte that is valid in the same cycle as `data_start_i`, or the first valid byte after it, takes position 0.
- R8: The position advances by one only on a valid byte and wraps from 7 to 0. Idle cycles do not move it.
- R9: `dout_vld_o` equals `din_vld_i` one cycle earlier. `dout_o` changes only one cycle after a valid input byte and otherwise holds its value.
- R10: `key_ok_o` stays low until the first completed UID load and then stays high until reset. Before any load the base key is zero.
- R11: A byte that enters in the same cycle as a completed UID load uses the old key. Bytes in later cycles use the new key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uid_byte_i | input | 8 | Serial UID byte |
| uid_byte_vld_i | input | 1 | Qualifies `uid_byte_i` |
| uid_vec_i | input | 64 | Parallel UID, byte k at [8k+7:8k] |
| uid_vec_ld_i | input | 1 | Loads `uid_vec_i` |
| data_start_i | input | 1 | Restarts group position at 0 |
| din_i | input | 8 | Scrambled payload byte |
| din_vld_i | input | 1 | Qualifies `din_i` |
| dout_o | output | 8 | Descrambled byte |
| dout_vld_o | output | 1 | Qualifies `dout_o` |
| key_ok_o | output | 1 | A key has been derived |

## Verification
The bench targets the eighth byte of each group. A design with the wrong offset, or with the offset at the wrong position, produces a wrong byte once every eight. Gaps in the valid stream and a start marker that arrives mid-group are driven on purpose. A counter that advanced on idle cycles, or that restarted on the cycle after the marker, would shift the offset to the wrong byte.

Loads are tested in several ways:
- Serial loads with gaps between bytes.
- Serial loads left unfinished.
- A parallel load that collides with a serial byte.
- A UID load in the same cycle as a data byte.

These cases expose three faults: a key that updates early, a key that sums a stale partial load, and a design that gives the serial path priority.

// File: rtl/unscr_pkg.sv
// Shared types for the payload descrambler.
// Assumes byte-wide payload and UID lanes.
package unscr_pkg;
    typedef logic [7:0] byte_t;
endpackage

// File: rtl/uid_key_gen.sv
// Derives the base key from a device UID.
// Accepts either a serial byte stream (UID_BYTES bytes per load) or a
// parallel word; the parallel word wins a same-cycle conflict.
// Assumes: the key register updates only when a full UID is in.
module uid_key_gen #(
    parameter int UID_BYTES = 8,
    parameter int DW        = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DW-1:0]           ser_byte_i,
    input  logic                    ser_vld_i,
    input  logic [UID_BYTES*DW-1:0] par_vec_i,
    input  logic                    par_ld_i,
    output logic [DW-1:0]           key_o,
    output logic                    key_ok_o
);
    localparam int CW = $clog2(UID_BYTES);

    logic [DW-1:0] part_sum [UID_BYTES+1];
    logic [DW-1:0] acc_q;
    logic [CW-1:0] cnt_q;

    // Adder chain over the parallel UID lanes.
    assign part_sum[0] = '0;
    for (genvar k = 0; k < UID_BYTES; k++) begin : g_sum
        assign part_sum[k+1] = part_sum[k] + par_vec_i[k*DW +: DW];
    end

    // Serial accumulation, key capture and key-valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            cnt_q    <= '0;
            key_o    <= '0;
            key_ok_o <= 1'b0;
        end else if (par_ld_i) begin
            acc_q    <= '0;
            cnt_q    <= '0;
            key_o    <= part_sum[UID_BYTES];
            key_ok_o <= 1'b1;
        end else if (ser_vld_i) begin
            if (cnt_q == CW'(UID_BYTES - 1)) begin
                acc_q    <= '0;
                cnt_q    <= '0;
                key_o    <= acc_q + ser_byte_i;
                key_ok_o <= 1'b1;
            end else begin
                acc_q <= acc_q + ser_byte_i;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/grp_pos_tracker.sv
// Tracks the position of the current payload byte inside its group.
// The start marker forces position 0 for the byte in its own cycle or
// the next valid byte; only valid bytes advance the position.
module grp_pos_tracker #(
    parameter int GROUP_LEN = 8,
    localparam int PW       = $clog2(GROUP_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          vld_i,
    output logic [PW-1:0] pos_o
);
    localparam logic [PW-1:0] LAST = PW'(GROUP_LEN - 1);

    logic [PW-1:0] pos_q;

    // Effective position of the byte present this cycle.
    always_comb pos_o = start_i ? '0 : pos_q;

    // Advance on valid bytes, restart on marker.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= '0;
        else if (vld_i)
            pos_q <= (pos_o == LAST) ? '0 : pos_o + 1'b1;
        else if (start_i)
            pos_q <= '0;
    end
endmodule

// File: rtl/xor_out_stage.sv
// Applies the position-dependent key byte and registers the result.
// The last group position gets the base key plus OFFSET (mod 2^DW).
// Output data holds when no valid byte enters.
module xor_out_stage #(
    parameter int           DW        = 8,
    parameter int           GROUP_LEN = 8,
    parameter logic [DW-1:0] OFFSET   = 8'h31,
    localparam int          PW        = $clog2(GROUP_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din_i,
    input  logic          vld_i,
    input  logic [PW-1:0] pos_i,
    input  logic [DW-1:0] key_i,
    output logic [DW-1:0] dout_o,
    output logic          dout_vld_o
);
    logic [DW-1:0] key_sel;

    // Pick the key byte for this position.
    always_comb key_sel = (pos_i == PW'(GROUP_LEN - 1)) ? key_i + OFFSET : key_i;

    // One-cycle output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_o     <= '0;
            dout_vld_o <= 1'b0;
        end else begin
            dout_vld_o <= vld_i;
            if (vld_i) dout_o <= din_i ^ key_sel;
        end
    end
endmodule

// File: rtl/payload_unscrambler.sv
// Top level of the keyed XOR payload descrambler.
// Assumes the frame parser pulses data_start_i before the first payload
// byte so header and padding bytes are never presented as data.
module payload_unscrambler #(
    parameter int                UID_BYTES = 8,
    parameter int                GROUP_LEN = 8,
    parameter logic [7:0]        OFFSET    = 8'h31
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [7:0]              uid_byte_i,
    input  logic                    uid_byte_vld_i,
    input  logic [UID_BYTES*8-1:0]  uid_vec_i,
    input  logic                    uid_vec_ld_i,
    input  logic                    data_start_i,
    input  logic [7:0]              din_i,
    input  logic                    din_vld_i,
    output logic [7:0]              dout_o,
    output logic                    dout_vld_o,
    output logic                    key_ok_o
);
    import unscr_pkg::*;
    localparam int PW = $clog2(GROUP_LEN);

    byte_t         key_base;
    logic [PW-1:0] grp_pos;

    uid_key_gen #(.UID_BYTES(UID_BYTES), .DW(8)) u_key (
        .clk(clk), .rst_n(rst_n),
        .ser_byte_i(uid_byte_i), .ser_vld_i(uid_byte_vld_i),
        .par_vec_i(uid_vec_i), .par_ld_i(uid_vec_ld_i),
        .key_o(key_base), .key_ok_o(key_ok_o)
    );

    grp_pos_tracker #(.GROUP_LEN(GROUP_LEN)) u_pos (
        .clk(clk), .rst_n(rst_n),
        .start_i(data_start_i), .vld_i(din_vld_i), .pos_o(grp_pos)
    );

    xor_out_stage #(.DW(8), .GROUP_LEN(GROUP_LEN), .OFFSET(OFFSET)) u_xor (
        .clk(clk), .rst_n(rst_n),
        .din_i(din_i), .vld_i(din_vld_i), .pos_i(grp_pos), .key_i(key_base),
        .dout_o(dout_o), .dout_vld_o(dout_vld_o)
    );
endmodule

// File: rtl/unscr_checker.sv
// Temporal checks for payload_unscrambler, attached with bind.
// Observes the top ports plus the internal base key register.
module unscr_checker #(
    parameter logic [7:0] OFFSET = 8'h31
) (
    input logic       clk,
    input logic       rst_n,
    input logic       uid_vec_ld_i,
    input logic       data_start_i,
    input logic [7:0] din_i,
    input logic       din_vld_i,
    input logic [7:0] dout_o,
    input logic       dout_vld_o,
    input logic       key_ok_o,
    input logic [7:0] key_q
);
    logic [7:0] key_last;
    always_comb key_last = key_q + OFFSET;

    // Valid delayed by exactly one cycle.
    assert_vld_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (dout_vld_o == $past(din_vld_i)));

    // Output data holds across idle input cycles.
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(din_vld_i)) |-> $stable(dout_o));

    // Key-valid never drops once set.
    assert_keyok_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(key_ok_o));

    // Parallel load always yields a valid key.
    assert_par_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        uid_vec_ld_i |=> key_ok_o);

    // Every output byte used either the base or the last-position key.
    assert_key_choice_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && dout_vld_o) |->
        (((dout_o ^ $past(din_i)) == $past(key_q)) ||
         ((dout_o ^ $past(din_i)) == $past(key_last))));

    // Marker byte takes position 0, so the base key.
    assert_marker_pos0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_start_i && din_vld_i) |=> ((dout_o ^ $past(din_i)) == $past(key_q)));
endmodule

bind payload_unscrambler unscr_checker #(.OFFSET(OFFSET)) u_chk (
    .clk(clk), .rst_n(rst_n), .uid_vec_ld_i(uid_vec_ld_i),
    .data_start_i(data_start_i), .din_i(din_i), .din_vld_i(din_vld_i),
    .dout_o(dout_o), .dout_vld_o(dout_vld_o), .key_ok_o(key_ok_o),
    .key_q(key_base)
);

// File: tb/payload_unscrambler_tb.sv
module payload_unscrambler_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] OFS = 8'h31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  uid_byte_i = '0;
    logic        uid_byte_vld_i = 1'b0;
    logic [63:0] uid_vec_i = '0;
    logic        uid_vec_ld_i = 1'b0;
    logic        data_start_i = 1'b0;
    logic [7:0]  din_i = '0;
    logic        din_vld_i = 1'b0;
    logic [7:0]  dout_o;
    logic        dout_vld_o;
    logic        key_ok_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model state
    logic [7:0] m_key = '0;
    logic       m_ok  = 1'b0;
    logic [7:0] m_acc = '0;
    int         m_cnt = 0;
    int         m_pos = 0;
    logic [7:0] m_dout = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    payload_unscrambler u_dut (
        .clk(clk), .rst_n(rst_n),
        .uid_byte_i(uid_byte_i), .uid_byte_vld_i(uid_byte_vld_i),
        .uid_vec_i(uid_vec_i), .uid_vec_ld_i(uid_vec_ld_i),
        .data_start_i(data_start_i), .din_i(din_i), .din_vld_i(din_vld_i),
        .dout_o(dout_o), .dout_vld_o(dout_vld_o), .key_ok_o(key_ok_o)
    );

    function automatic logic [7:0] uid_sum(input logic [63:0] v);
        logic [7:0] s = '0;
        for (int k = 0; k < 8; k++) s = s + v[k*8 +: 8];
        return s;
    endfunction

    function automatic logic [7:0] key_for(input logic [7:0] k, input int pos);
        return (pos == 7) ? k + OFS : k;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance one clock with the inputs currently driven, then compare.
    task automatic tick();
        int pos_eff;
        bit vld;
        pos_eff = data_start_i ? 0 : m_pos;
        vld = din_vld_i;
        if (vld) begin
            m_dout = din_i ^ key_for(m_key, pos_eff);   // R11: old key in load cycle
            m_pos  = (pos_eff == 7) ? 0 : pos_eff + 1;  // R8
        end else if (data_start_i) m_pos = 0;
        if (uid_vec_ld_i) begin                          // R4
            m_key = uid_sum(uid_vec_i); m_ok = 1'b1; m_acc = '0; m_cnt = 0;
        end else if (uid_byte_vld_i) begin               // R3
            if (m_cnt == 7) begin
                m_key = m_acc + uid_byte_i; m_ok = 1'b1; m_acc = '0; m_cnt = 0;
            end else begin
                m_acc = m_acc + uid_byte_i; m_cnt++;
            end
        end
        @(posedge clk); @(negedge clk);
        check(dout_vld_o == vld, "R9 valid", dout_vld_o, vld);
        check(dout_o == m_dout, (pos_eff == 7) ? "R6 data" : "R5 data", dout_o, m_dout);
        check(key_ok_o == m_ok, "R10 key_ok", key_ok_o, m_ok);
    endtask

    task automatic idle();
        uid_byte_vld_i = 0; uid_vec_ld_i = 0; data_start_i = 0; din_vld_i = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        check(dout_vld_o == 0 && key_ok_o == 0 && dout_o == 0, "R1 in reset", dout_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dout_vld_o == 0 && key_ok_o == 0 && dout_o == 0, "R1 after reset", dout_o, 0);

        // R10: before any load key is zero; pos 7 still gets offset
        data_start_i = 1;
        for (int i = 0; i < 8; i++) begin
            din_i = 8'(i * 17); din_vld_i = 1; tick(); data_start_i = 0;
        end
        idle();

        // R2: parallel load, lane order
        uid_vec_i = 64'h0807_0605_0403_0201; uid_vec_ld_i = 1; tick(); idle(); tick();
        check(m_key == 8'h24, "R2 model sum", m_key, 8'h24);
        // R7/R8: marker then stream with gaps, 56 bytes
        data_start_i = 1; tick(); data_start_i = 0;
        for (int i = 0; i < 56; i++) begin
            din_i = 8'($urandom); din_vld_i = 1; tick();
            din_vld_i = 0; if (i % 5 == 0) tick();
        end
        // R7: marker mid-group with same-cycle byte
        din_i = 8'h5A; din_vld_i = 1; tick(); tick();
        data_start_i = 1; din_i = 8'hA5; tick(); data_start_i = 0;
        for (int i = 0; i < 9; i++) begin din_i = 8'(i); tick(); end
        idle();

        // R3: serial load with gaps; partial load leaves key
        for (int i = 0; i < 5; i++) begin
            uid_byte_i = 8'(8'h40 + i); uid_byte_vld_i = 1; tick(); uid_byte_vld_i = 0; tick();
        end
        din_i = 8'h11; din_vld_i = 1; tick(); din_vld_i = 0;
        for (int i = 0; i < 3; i++) begin
            uid_byte_i = 8'(8'h90 + i); uid_byte_vld_i = 1; tick();
        end
        idle(); tick();
        // R4: parallel wins over colliding serial byte, discards partial
        uid_byte_i = 8'hFF; uid_byte_vld_i = 1; tick();
        uid_vec_i = 64'hCDAB_3EED_FFFF_0000; uid_vec_ld_i = 1; tick(); idle();
        for (int i = 0; i < 8; i++) begin uid_byte_i = 8'h01; uid_byte_vld_i = 1; tick(); end
        idle();
        // R11: load in same cycle as data byte
        uid_vec_i = 64'h1122_3344_5566_7788; uid_vec_ld_i = 1; din_i = 8'h77; din_vld_i = 1; tick();
        uid_vec_ld_i = 0; tick(); idle(); tick();

        // Random phase
        for (int c = 0; c < 4000; c++) begin
            int r = int'($urandom % 100);
            data_start_i   = (r < 4);
            din_vld_i      = ($urandom % 4) != 0;
            din_i          = 8'($urandom);
            uid_vec_ld_i   = (r >= 97);
            uid_vec_i      = {$urandom, $urandom};
            uid_byte_vld_i = (r >= 80 && r < 88);
            uid_byte_i     = 8'($urandom);
            tick();
        end
        idle(); tick();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule